// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational 32-bit binary adder. It takes two 32-bit operands and a carry input, and returns a 32-bit sum and a carry output. The block has no clock and no internal state, so its outputs follow its inputs through logic alone.

Each bit forms a generate term and a propagate term. Every 4-bit slice reduces its bit terms to one group generate and one group propagate. Inside each 16-bit section, a lookahead unit turns the four group pairs into the carry for each slice. It computes every carry as a flat sum of products, so no carry ripples inside the unit.

The two sections are chained end to end. The carry output of the lower section is the carry input of the upper section. The top-level interface is fixed, so a different internal adder can take this block's place without any change at its boundary.

Top module: `cla_adder32`

## Requirements
- R1: `sum` equals the low 32 bits of the arithmetic total a + b + cin, with the operands taken as unsigned.
- R2: `cout` equals bit 32 of the same unsigned total, so {cout, sum} is the complete 33-bit result.
- R3: When every bit position has exactly one operand bit set and cin is 1, the carry propagates through all eight slices: sum is 0x00000000 and cout is 1.
- R4: A carry produced inside one 4-bit slice reaches the next slice. 0x0000000F + 0x00000001 gives 0x00000010, and 0x0FFFFFFF + 0x00000001 gives 0x10000000.
- R5: A carry leaving the lower 16-bit section (bits 15..0) enters the upper section (bits 31..16). 0x0000FFFF + 0x00000001 gives 0x00010000 with cout 0.
- R6: All-zero operands with cin 0 give sum 0 and cout 0. With cin 1 they give sum 0x00000001 and cout 0.
- R7: Swapping a and b leaves {cout, sum} unchanged.
- R8: The largest operands, 0xFFFFFFFF + 0xFFFFFFFF, give sum 0xFFFFFFFE with cout 1 when cin is 0, and sum 0xFFFFFFFF with cout 1 when cin is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First unsigned operand |
| b | input | 32 | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Low 32 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 31 |

## Verification
The bench targets the longest carry paths, because those paths are where a lookahead adder fails.

- **Full propagate (all bits propagate, cin 1).** A wrong group-propagate product or a dropped cin term would leave ones in the sum or clear cout.
- **Slice and section boundary cases.** A lookahead unit that indexed its groups off by one, or a lower section whose carry never reached the upper section, would leave the carry stuck at bit 4 or bit 16.
- **Alternating patterns and maximum operands.** These mix the kill, generate and propagate cases in every slice, so a swapped G/P product term shows up as a wrong bit.
- **Random and swapped operands.** These catch any asymmetry between the a and b paths.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Widest span the span function accepts.
  localparam int MAX_SPAN = 32;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Combine a more significant pair (hi) with a less significant pair (lo).
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Combined generate/propagate over positions 0..upto.
  // Each caller passes a constant upto, so every result is a flat
  // function of its inputs and no carry chain is formed.
  function automatic gp_t span_gp(input logic [MAX_SPAN-1:0] gv,
                                  input logic [MAX_SPAN-1:0] pv,
                                  input int upto);
    gp_t acc;
    gp_t cur;
    acc.g = gv[0];
    acc.p = pv[0];
    for (int i = 1; i < MAX_SPAN; i++) begin
      if (i <= upto) begin
        cur.g = gv[i];
        cur.p = pv[i];
        acc = gp_merge(cur, acc);
      end
    end
    return acc;
  endfunction

endpackage

// File: rtl/cla_pg_slice.sv
module cla_pg_slice
  import cla_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         grp_g,
  output logic         grp_p
);

  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W-1:0] bit_c;
  gp_t          grp;

  assign bit_g = a & b;
  assign bit_p = a ^ b;

  always_comb begin
    gp_t t;
    bit_c[0] = cin;
    for (int k = 1; k < W; k++) begin
      t = span_gp(MAX_SPAN'(bit_g), MAX_SPAN'(bit_p), k - 1);
      bit_c[k] = t.g | (t.p & cin);
    end
  end

  assign sum   = bit_p ^ bit_c;
  assign grp   = span_gp(MAX_SPAN'(bit_g), MAX_SPAN'(bit_p), W - 1);
  assign grp_g = grp.g;
  assign grp_p = grp.p;

  always_comb begin
    // R3: a slice that propagates as a whole cannot also generate.
    a_r3_prop_excl: assert (!(grp_g && grp_p))
      else $error("slice reports both group generate and propagate");
    // R1: the slice result plus its group carry equals the slice total.
    a_r1_slice_sum: assert ({grp_g | (grp_p & cin), sum} ==
                            ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
      else $error("slice sum disagrees with its operands");
  end

endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import cla_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] grp_g,
  input  logic [N-1:0] grp_p,
  input  logic         cin,
  output logic [N-1:0] grp_cin,
  output logic         cout
);

  logic [N:0] carries;

  always_comb begin
    gp_t t;
    carries[0] = cin;
    for (int k = 1; k <= N; k++) begin
      t = span_gp(MAX_SPAN'(grp_g), MAX_SPAN'(grp_p), k - 1);
      carries[k] = t.g | (t.p & cin);
    end
  end

  assign grp_cin = carries[N-1:0];
  assign cout    = carries[N];

  always_comb begin
    for (int k = 0; k < N; k++) begin
      // R4: each expanded carry matches the step-by-step recurrence.
      a_r4_carry_chain: assert (carries[k+1] == (grp_g[k] | (grp_p[k] & carries[k])))
        else $error("lookahead carry %0d breaks the recurrence", k + 1);
    end
  end

endmodule

// File: rtl/cla_section.sv
module cla_section #(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 4
) (
  input  logic [SLICE_W*SLICES-1:0] a,
  input  logic [SLICE_W*SLICES-1:0] b,
  input  logic                      cin,
  output logic [SLICE_W*SLICES-1:0] sum,
  output logic                      cout
);

  logic [SLICES-1:0] grp_g;
  logic [SLICES-1:0] grp_p;
  logic [SLICES-1:0] grp_cin;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    cla_pg_slice #(.W(SLICE_W)) u_slice (
      .a    (a[s*SLICE_W +: SLICE_W]),
      .b    (b[s*SLICE_W +: SLICE_W]),
      .cin  (grp_cin[s]),
      .sum  (sum[s*SLICE_W +: SLICE_W]),
      .grp_g(grp_g[s]),
      .grp_p(grp_p[s])
    );
  end

  cla_lookahead #(.N(SLICES)) u_look (
    .grp_g  (grp_g),
    .grp_p  (grp_p),
    .cin    (cin),
    .grp_cin(grp_cin),
    .cout   (cout)
  );

endmodule

// File: rtl/cla_adder32.sv
module cla_adder32 #(
  parameter int WIDTH          = 32,
  parameter int SLICE_W        = 4,
  parameter int SLICES_PER_SEC = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int SEC_W   = SLICE_W * SLICES_PER_SEC;
  localparam int NUM_SEC = WIDTH / SEC_W;

  // Carry passed between sections; this is the only ripple in the adder.
  logic [NUM_SEC:0] sec_carry;

  assign sec_carry[0] = cin;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    cla_section #(.SLICE_W(SLICE_W), .SLICES(SLICES_PER_SEC)) u_sec (
      .a   (a[s*SEC_W +: SEC_W]),
      .b   (b[s*SEC_W +: SEC_W]),
      .cin (sec_carry[s]),
      .sum (sum[s*SEC_W +: SEC_W]),
      .cout(sec_carry[s+1])
    );
  end

  assign cout = sec_carry[NUM_SEC];

  always_comb begin
    // R1 and R2: the full 33-bit result equals the unsigned total.
    a_r2_total: assert ({cout, sum} ==
                        ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("adder result disagrees with its operands");
  end

endmodule

// File: tb/test_cla_adder32.sv
module test_cla_adder32;

  logic        clk = 1'b0;
  logic [31:0] a   = '0;
  logic [31:0] b   = '0;
  logic        cin = 1'b0;
  logic [31:0] sum;
  logic        cout;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  cla_adder32 i_cla_adder32 (
    .a   (a),
    .b   (b),
    .cin (cin),
    .sum (sum),
    .cout(cout)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - failures, checks);
  endtask

  // Drive one vector after a rising edge; check at the following falling edge.
  task automatic run_case(input logic [31:0] x, input logic [31:0] y,
                          input logic ci, input string req);
    logic [32:0] expv;
    @(posedge clk);
    a   = x;
    b   = y;
    cin = ci;
    @(negedge clk);
    expv = {1'b0, x} + {1'b0, y} + {32'd0, ci};
    checks++;
    if ({cout, sum} !== expv) begin
      failures++;
      $display("FAIL %s: a=%h b=%h cin=%b got cout=%b sum=%h expected cout=%b sum=%h",
               req, x, y, ci, cout, sum, expv[32], expv[31:0]);
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    checks++;
    if ({cout, sum} !== 33'd0) begin
      failures++;
      $display("FAIL R6 idle: got cout=%b sum=%h expected cout=0 sum=00000000", cout, sum);
    end
  endtask

  task automatic t_zero_and_cin();
    run_case(32'h0, 32'h0, 1'b0, "R6");
    run_case(32'h0, 32'h0, 1'b1, "R6");
  endtask

  task automatic t_full_propagate();
    run_case(32'hFFFFFFFF, 32'h00000000, 1'b1, "R3");
    run_case(32'hAAAAAAAA, 32'h55555555, 1'b1, "R3");
    run_case(32'hF0F0F0F0, 32'h0F0F0F0F, 1'b1, "R3");
    run_case(32'hAAAAAAAA, 32'h55555555, 1'b0, "R1");
  endtask

  task automatic t_slice_boundaries();
    run_case(32'h0000000F, 32'h00000001, 1'b0, "R4");
    run_case(32'h0FFFFFFF, 32'h00000001, 1'b0, "R4");
    for (int k = 0; k < 8; k++)
      run_case(32'h0000000F << (4 * k), 32'h00000001 << (4 * k), 1'b0, "R4");
    run_case(32'h00000007, 32'h00000008, 1'b1, "R4");
  endtask

  task automatic t_section_boundary();
    run_case(32'h0000FFFF, 32'h00000001, 1'b0, "R5");
    run_case(32'h0000FFFF, 32'h00000000, 1'b1, "R5");
    run_case(32'h00008000, 32'h00008000, 1'b0, "R5");
    run_case(32'hFFFF0000, 32'h0000FFFF, 1'b1, "R2");
  endtask

  task automatic t_alternating();
    run_case(32'hAAAAAAAA, 32'hAAAAAAAA, 1'b0, "R1");
    run_case(32'h55555555, 32'h55555555, 1'b1, "R1");
    run_case(32'hCCCCCCCC, 32'h33333333, 1'b0, "R1");
    run_case(32'h80000000, 32'h80000000, 1'b0, "R2");
  endtask

  task automatic t_max_operands();
    run_case(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R8");
    run_case(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R8");
  endtask

  task automatic t_random_swap();
    for (int n = 0; n < 300; n++) begin
      logic [31:0] x;
      logic [31:0] y;
      logic        ci;
      x  = $urandom;
      y  = $urandom;
      ci = 1'($urandom);
      run_case(x, y, ci, "R1");
      run_case(y, x, ci, "R7");
    end
  endtask

  initial begin
    t_idle();
    t_zero_and_cin();
    t_full_propagate();
    t_slice_boundaries();
    t_section_boundary();
    t_alternating();
    t_max_operands();
    t_random_swap();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: got no completion expected completion within 200000 cycles");
    summary();
    $finish;
  end

endmodule